// File: doc/BRIEF.md
# Fractional Clock Synthesizer Channel

This block is one output channel of a multi-channel digital frequency synthesizer. It runs on a fast clock `clk` and produces `clk_out`. The output period comes from four settings: a coarse integer step (`md`), a fine fractional step (`pe`), a power-of-two post divider (`sdiv`) and an optional divide by three. Internally a phase accumulator emits a tick at a fractional average rate. A post divider counts those ticks to form each half of the output period.

Settings are written into a shadow word. The shadow word only moves toward the running set when the program-enable input is pulsed high and then low. The captured word is then applied at the next rising edge of `clk_out`, so no output pulse is ever cut short. When the output is already stopped, the word is applied at once. A standby input and a channel clear input both stop the output and hold it low. A channel whose `md`, `pe` and `sdiv` are all zero counts as unprogrammed and stays silent.

The reference rate `fin` equals half the `clk` rate. With that, the output frequency is fin·32·2^20 / ((2^20·(32+md) + 32·pe) · 2^sdiv · ns).

Top module: `fsyn_channel`

## Requirements
- R1: After reset, `clk_out` is low and the running settings are all zero.
- R2: The settings word carries `pe` in bits 14:0, `md` in bits 19:15 and `sdiv` in bits 23:20. Bit 24 is an active-low divide-by-three control: 0 gives ns = 3, and 1 gives ns = 1.
- R3: In `clk` cycles, the average `clk_out` period is 2·2^sdiv·ns·(2^15·(32+md)+pe)/2^20. Over any long window, the count of rising edges is within one of the exact value.
- R4: A settings write does not change the output until `prog_en` goes from 1 to 0. Holding `prog_en` high does not apply it either.
- R5: While the output runs, a captured word takes effect at the next rising edge of `clk_out`. The high and low phases in progress finish with the old settings.
- R6: While the output is stopped (standby, clear or unprogrammed), a captured word becomes the running set at once, and it governs the first period after restart.
- R7: With `run` low, `clk_out` is low from the next cycle on. Raising `run` restarts the output from a fresh phase.
- R8: With `chan_clr` high, `clk_out` is low from the next cycle on, and the output restarts once the clear is released.
- R9: If the running `md`, `pe` and `sdiv` are all zero, `clk_out` stays low whatever the value of bit 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synthesizer clock (twice the reference rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Writes `cfg_word` into the shadow word |
| cfg_word | input | 25 | Settings word (fields per R2) |
| prog_en | input | 1 | Program enable; a 1-then-0 pulse captures the shadow word |
| run | input | 1 | High to run, low for standby |
| chan_clr | input | 1 | Channel clear, active high |
| clk_out | output | 1 | Synthesized output clock |

## Verification
A wrong accumulator remainder does not show up on any single edge. It shows up as drift in the edge count over a few thousand cycles, so fractional settings are judged by counting edges over a window, and integer settings by exact period. A lost or stuck pending flag shows within one or two output periods: the period either never changes after the pulse or changes before it. A commit that happens at the wrong moment shortens the high or low phase that is in progress. Both phases around a mid-period pulse are therefore measured sample by sample.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  parameter int unsigned PE_W = 15;
  parameter int unsigned MD_W = 5;
  parameter int unsigned SD_W = 4;
  localparam int unsigned CFG_W = PE_W + MD_W + SD_W + 1;
  localparam int unsigned ACC_W = MD_W + PE_W + 2;
  localparam int unsigned CNT_W = (1 << SD_W) + 1;

  typedef struct packed {
    logic            bypass3;
    logic [SD_W-1:0] sdiv;
    logic [MD_W-1:0] md;
    logic [PE_W-1:0] pe;
  } fsyn_cfg_t;
endpackage

// File: rtl/fsyn_cfg_stage.sv
module fsyn_cfg_stage
  import fsyn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  fsyn_cfg_t cfg_in,
  input  logic      prog_en,
  input  logic      stopped,
  input  logic      boundary,
  output fsyn_cfg_t act_cfg,
  output logic      commit
);
  fsyn_cfg_t shadow_q, shadow_d;
  fsyn_cfg_t staged_q, staged_d;
  fsyn_cfg_t act_q, act_d;
  logic      pend_q, pend_d;
  logic      pen_q;
  logic      fall;

  always_comb begin
    fall     = pen_q & ~prog_en;
    commit   = pend_q & (stopped | boundary);
    shadow_d = cfg_wr ? cfg_in : shadow_q;
    staged_d = fall ? shadow_q : staged_q;
    act_d    = commit ? staged_q : act_q;
    pend_d   = fall | (pend_q & ~commit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      staged_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
      pen_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      staged_q <= staged_d;
      act_q    <= act_d;
      pend_q   <= pend_d;
      pen_q    <= prog_en;
    end
  end

  assign act_cfg = act_q;
endmodule

// File: rtl/fsyn_phase_acc.sv
module fsyn_phase_acc
  import fsyn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            restart,
  input  logic [MD_W-1:0] md,
  input  logic [PE_W-1:0] pe,
  output logic            tick
);
  localparam logic [ACC_W-1:0] INC = ACC_W'(1) << (MD_W + PE_W);

  logic [ACC_W-1:0] acc_q, acc_d, acc_sum, den;

  always_comb begin
    den     = (ACC_W'({1'b1, md}) << PE_W) | ACC_W'(pe);
    acc_sum = acc_q + INC;
    tick    = en && (acc_sum >= den);
    if (!en || restart)
      acc_d = '0;
    else if (tick)
      acc_d = acc_sum - den;
    else
      acc_d = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/fsyn_post_div.sv
module fsyn_post_div
  import fsyn_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic [SD_W-1:0] sdiv,
  input  logic            bypass3,
  output logic            clk_out,
  output logic            boundary
);
  logic [CNT_W-1:0] half, cnt_q, cnt_d;
  logic             out_q, out_d, cnt_last;

  always_comb begin
    half     = bypass3 ? (CNT_W'(1) << sdiv) : (CNT_W'(3) << sdiv);
    cnt_last = (cnt_q == half - CNT_W'(1));
    boundary = tick && cnt_last && !out_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    if (!en) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick) begin
      if (cnt_last) begin
        cnt_d = '0;
        out_d = ~out_q;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_out = out_q;
endmodule

// File: rtl/fsyn_channel.sv
module fsyn_channel
  import fsyn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             prog_en,
  input  logic             run,
  input  logic             chan_clr,
  output logic             clk_out
);
  fsyn_cfg_t act_cfg;
  logic      commit, boundary, tick, running, programmed;

  always_comb begin
    programmed = (act_cfg.md != '0) || (act_cfg.pe != '0) || (act_cfg.sdiv != '0);
    running    = run && !chan_clr && programmed;
  end

  fsyn_cfg_stage u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_in   (fsyn_cfg_t'(cfg_word)),
    .prog_en  (prog_en),
    .stopped  (!running),
    .boundary (boundary),
    .act_cfg  (act_cfg),
    .commit   (commit)
  );

  fsyn_phase_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (running),
    .restart (commit),
    .md      (act_cfg.md),
    .pe      (act_cfg.pe),
    .tick    (tick)
  );

  fsyn_post_div u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (running),
    .tick     (tick),
    .sdiv     (act_cfg.sdiv),
    .bypass3  (act_cfg.bypass3),
    .clk_out  (clk_out),
    .boundary (boundary)
  );
endmodule

// File: rtl/fsyn_channel_chk.sv
module fsyn_channel_chk
  import fsyn_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      run,
  input logic      chan_clr,
  input logic      clk_out,
  input fsyn_cfg_t act_cfg,
  input logic      running
);
  assert_standby_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_out);

  assert_clear_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clr |=> !clk_out);

  assert_unprog_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.md == '0 && act_cfg.pe == '0 && act_cfg.sdiv == '0) |=> !clk_out);

  assert_commit_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && (act_cfg != $past(act_cfg))) |-> $rose(clk_out));

  assert_high_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> $past(running));
endmodule

bind fsyn_channel fsyn_channel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .chan_clr (chan_clr),
  .clk_out  (clk_out),
  .act_cfg  (act_cfg),
  .running  (running)
);

// File: tb/fsyn_channel_tb.sv
module fsyn_channel_tb;
  logic        clk, rst_n, cfg_wr, prog_en, run, chan_clr, clk_out;
  logic [24:0] cfg_word;
  int checks = 0;
  int errors = 0;

  fsyn_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .prog_en(prog_en), .run(run), .chan_clr(chan_clr), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [24:0] mk(input logic byp, input int sd, input int md, input int pe);
    return {byp, 4'(sd), 5'(md), 15'(pe)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [24:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_word = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_prog();
    @(negedge clk); prog_en = 1'b1;
    @(negedge clk); prog_en = 1'b0;
  endtask

  task automatic wait_rise(output int cyc);
    logic prev;
    prev = clk_out;
    cyc = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cyc++;
      if (!prev && clk_out) return;
      prev = clk_out;
    end
    cyc = -1;
  endtask

  task automatic measure_period(output int per);
    int c;
    wait_rise(c);
    wait_rise(c);
    wait_rise(per);
  endtask

  task automatic count_low(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
  endtask

  task automatic t_reset_unprog();
    int h;
    check(clk_out == 1'b0, "R1 reset output", clk_out, 0);
    count_low(64, h);
    check(h == 0, "R9 idle after reset", h, 0);
    write_cfg(mk(1'b1, 0, 0, 0));
    pulse_prog();
    count_low(100, h);
    check(h == 0, "R9 bypass bit only", h, 0);
  endtask

  task automatic t_exact(input logic byp, input int sd, input int md, input string req, input int exp);
    int per;
    write_cfg(mk(byp, sd, md, 0));
    pulse_prog();
    measure_period(per);
    check(per == exp, req, per, exp);
  endtask

  task automatic t_window(input logic byp, input int sd, input int md, input int pe, input int n, input string req);
    int c, edges;
    longint den, ns, expv;
    logic prev;
    write_cfg(mk(byp, sd, md, pe));
    pulse_prog();
    wait_rise(c);
    wait_rise(c);
    ns = byp ? 1 : 3;
    den = ((longint'(32 + md)) << 15) + pe;
    expv = (longint'(n) << 20) / (2 * ns * (longint'(1) << sd) * den);
    edges = 0;
    prev = clk_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!prev && clk_out) edges++;
      prev = clk_out;
    end
    check(edges >= expv - 1 && edges <= expv + 1, req, edges, expv);
  endtask

  task automatic t_shadow();
    int per;
    write_cfg(mk(1'b1, 1, 0, 0));
    pulse_prog();
    measure_period(per);
    check(per == 4, "R3 base period", per, 4);
    write_cfg(mk(1'b1, 3, 0, 0));
    measure_period(per);
    check(per == 4, "R4 write without pulse", per, 4);
    @(negedge clk); prog_en = 1'b1;
    measure_period(per);
    check(per == 4, "R4 enable held high", per, 4);
    @(negedge clk); prog_en = 1'b0;
    measure_period(per);
    check(per == 16, "R4 applied after fall", per, 16);
  endtask

  task automatic t_boundary();
    int per, c, h, l;
    write_cfg(mk(1'b1, 4, 0, 0));
    pulse_prog();
    wait_rise(c);
    write_cfg(mk(1'b1, 1, 0, 0));
    wait_rise(c);
    wait_rise(c);
    h = 1;
    prog_en = 1'b1;
    @(negedge clk);
    if (clk_out) h++;
    prog_en = 1'b0;
    for (int i = 0; i < 100 && clk_out; i++) begin
      @(negedge clk);
      if (clk_out) h++;
    end
    l = 0;
    for (int i = 0; i < 100 && !clk_out; i++) begin
      l++;
      @(negedge clk);
    end
    check(h == 16, "R5 high phase kept", h, 16);
    check(l == 16, "R5 low phase kept", l, 16);
    wait_rise(per);
    check(per == 4, "R5 new period after edge", per, 4);
  endtask

  task automatic t_standby();
    int h, per;
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    check(clk_out == 1'b0, "R7 standby low", clk_out, 0);
    write_cfg(mk(1'b1, 2, 0, 0));
    pulse_prog();
    count_low(100, h);
    check(h == 0, "R7 stays low in standby", h, 0);
    @(negedge clk); run = 1'b1;
    wait_rise(per);
    wait_rise(per);
    check(per == 8, "R6 applied while stopped", per, 8);
  endtask

  task automatic t_clear();
    int h, per;
    @(negedge clk); chan_clr = 1'b1;
    @(negedge clk);
    check(clk_out == 1'b0, "R8 clear low", clk_out, 0);
    count_low(50, h);
    check(h == 0, "R8 stays low", h, 0);
    @(negedge clk); chan_clr = 1'b0;
    measure_period(per);
    check(per == 8, "R8 restart period", per, 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_word = '0; prog_en = 1'b0;
    run = 1'b1; chan_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_unprog();
    t_exact(1'b1, 1, 0, "R3 R2 sdiv1 bypass", 4);
    t_exact(1'b0, 2, 0, "R3 R2 div3 sdiv2", 24);
    t_exact(1'b1, 1, 16, "R3 R2 md16", 6);
    t_exact(1'b1, 8, 0, "R3 sdiv8", 512);
    t_window(1'b1, 3, 0, 16384, 6500, "R3 R2 fractional pe");
    t_window(1'b0, 0, 1, 0, 9900, "R3 md1 div3");
    t_window(1'b1, 2, 5, 1000, 8000, "R3 mixed md pe");
    t_shadow();
    t_boundary();
    t_standby();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule